// File: doc/BRIEF.md
# ADC Scan Sequence Controller

This block drives an analog-to-digital converter through programmed lists of channels. There are two lists. The regular list has up to sixteen slots and the injected list has up to four. Each list has a length field. A start strobe for a list makes the controller issue a one-cycle conversion pulse together with a channel number. It then waits for the converter's done handshake. When scan mode is on, each done launches the next slot of the list with no further trigger. When continuous mode is on, the controller wraps from the last slot back to the first.

Regular results go to one shared data register. Each write raises a DMA request that stays high until it is acknowledged. A regular result that arrives while the previous one is still unacknowledged produces an overrun pulse. Injected results are kept apart in one data register per rank, and a pulse marks the end of each pass through either list.

Top module: `adcSeqCtrl`

## Requirements
- R1: After reset, `convStart`, `busy`, `dmaReq`, `overrun`, both end-of-sequence pulses, `regData` and every rank of `injData` are zero.
- R2: When the controller is idle, a start strobe makes `convStart` high for one cycle on the next cycle. `busy` rises with it, and `convChan` holds slot 0 of the chosen list.
- R3: Slot k of a list takes bits [5k+4:5k] of `regChans` or `injChans`. A length field holds the slot count minus one: 0..15 in the 4-bit `regLen` and 0..3 in the 2-bit `injLen`. With `scanEn` high, slots 0 to the length are converted in ascending order, each exactly once per pass.
- R4: A done handshake on a slot that is not the last gives `convStart` with the next slot's channel on the following cycle, with no strobe needed.
- R5: With `scanEn` low, only slot 0 of the list is converted, whatever the length field holds.
- R6: With `contEn` high at the last slot's done, conversion restarts at slot 0. Clearing `contEn` during a pass stops the controller after that pass ends.
- R7: A one-cycle `regEos` or `injEos` pulse follows the done of the last slot of a pass, whether or not the controller wraps.
- R8: Each regular done loads `convData` into `regData` on the next cycle and sets `dmaReq`. `dmaReq` stays high until `dmaAck` is sampled high.
- R9: A regular done that arrives while `dmaReq` is high and `dmaAck` is low gives a one-cycle `overrun` pulse.
- R10: An injected done on rank r loads `injData` bits [12r+11:12r]. `regData` and `dmaReq` are left unchanged.
- R11: Start strobes are ignored while a pass is running. If both strobes arrive together while idle, the injected list runs and the regular strobe is dropped.
- R12: A done handshake while idle changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanEn | input | 1 | Step through the whole list |
| contEn | input | 1 | Wrap to slot 0 after the last slot |
| regLen | input | 4 | Regular slot count minus one |
| regChans | input | 80 | Regular slot channels, 5 bits each |
| injLen | input | 2 | Injected slot count minus one |
| injChans | input | 20 | Injected slot channels, 5 bits each |
| regStart | input | 1 | Regular list start strobe |
| injStart | input | 1 | Injected list start strobe |
| convDone | input | 1 | Converter done handshake |
| convData | input | 12 | Converter result |
| dmaAck | input | 1 | DMA acknowledge |
| convStart | output | 1 | Start-conversion pulse |
| convChan | output | 5 | Channel to convert |
| busy | output | 1 | A pass is running |
| regEos | output | 1 | Regular end-of-sequence pulse |
| injEos | output | 1 | Injected end-of-sequence pulse |
| regData | output | 12 | Regular result register |
| dmaReq | output | 1 | DMA request |
| overrun | output | 1 | Regular result overrun pulse |
| injData | output | 48 | Injected result registers, 12 bits per rank |

## Verification
The hardest situation to reach is clearing continuous mode in the middle of a wrapped pass. The stimulus counts finished conversions and drops `contEn` while the last slot of the second pass is still converting, so the controller has to stop after exactly four conversions. The overrun case is reached by turning the automatic acknowledge off during a three-slot regular pass. A stray start strobe is injected partway through an injected pass, and the bench expects it to produce no extra conversion.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;
  localparam int REG_SLOTS_DEF = 16;
  localparam int INJ_SLOTS_DEF = 4;
  localparam int CHAN_W_DEF    = 5;
  localparam int DATA_W_DEF    = 12;
  localparam int INJ_RANK_W    = $clog2(INJ_SLOTS_DEF);

  typedef enum logic {GRP_REG = 1'b0, GRP_INJ = 1'b1} grpE;

  // Strobes from the sequencer to the result datapath.
  typedef struct packed {
    logic                  wrReg;
    logic                  wrInj;
    logic [INJ_RANK_W-1:0] injRank;
  } dpStrobeT;
endpackage

// File: rtl/adcSeqControl.sv
module adcSeqControl
  import adcSeqPkg::*;
#(
  parameter int REG_SLOTS = REG_SLOTS_DEF,
  parameter int INJ_SLOTS = INJ_SLOTS_DEF,
  parameter int CHAN_W    = CHAN_W_DEF
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        scanEn,
  input  logic                        contEn,
  input  logic [$clog2(REG_SLOTS)-1:0] regLen,
  input  logic [REG_SLOTS*CHAN_W-1:0] regChans,
  input  logic [$clog2(INJ_SLOTS)-1:0] injLen,
  input  logic [INJ_SLOTS*CHAN_W-1:0] injChans,
  input  logic                        regStart,
  input  logic                        injStart,
  input  logic                        convDone,
  output logic                        convStart,
  output logic [CHAN_W-1:0]           convChan,
  output logic                        busy,
  output logic                        regEos,
  output logic                        injEos,
  output dpStrobeT                    strb
);
  localparam int REG_LEN_W = $clog2(REG_SLOTS);
  localparam int INJ_LEN_W = $clog2(INJ_SLOTS);

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} stateE;

  stateE                state;
  grpE                  group;
  logic [REG_LEN_W-1:0] slot;
  logic [CHAN_W-1:0]    regTab [REG_SLOTS];
  logic [CHAN_W-1:0]    injTab [INJ_SLOTS];
  logic [REG_LEN_W-1:0] curLen;
  logic [REG_LEN_W-1:0] nextSlot;
  logic [CHAN_W-1:0]    nextChan;
  logic                 lastSlot;
  logic                 doneHit;

  // Unpack the slot fields into lookup arrays.
  for (genvar g = 0; g < REG_SLOTS; g++) begin : gRegTab
    assign regTab[g] = regChans[g*CHAN_W +: CHAN_W];
  end
  for (genvar g = 0; g < INJ_SLOTS; g++) begin : gInjTab
    assign injTab[g] = injChans[g*CHAN_W +: CHAN_W];
  end

  always_comb begin
    curLen   = (group == GRP_INJ) ? REG_LEN_W'(injLen) : regLen;
    lastSlot = !scanEn || (slot == curLen);
    nextSlot = lastSlot ? '0 : slot + 1'b1;
    nextChan = (group == GRP_INJ) ? injTab[nextSlot[INJ_LEN_W-1:0]] : regTab[nextSlot];
    doneHit  = (state == ST_WAIT) && convDone;
    strb.wrReg   = doneHit && (group == GRP_REG);
    strb.wrInj   = doneHit && (group == GRP_INJ);
    strb.injRank = slot[INJ_LEN_W-1:0];
  end

  assign busy = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      group     <= GRP_REG;
      slot      <= '0;
      convStart <= 1'b0;
      convChan  <= '0;
      regEos    <= 1'b0;
      injEos    <= 1'b0;
    end else begin
      convStart <= 1'b0;
      regEos    <= 1'b0;
      injEos    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (injStart) begin
            group     <= GRP_INJ;
            slot      <= '0;
            convStart <= 1'b1;
            convChan  <= injTab[0];
            state     <= ST_WAIT;
          end else if (regStart) begin
            group     <= GRP_REG;
            slot      <= '0;
            convStart <= 1'b1;
            convChan  <= regTab[0];
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (convDone) begin
            regEos <= lastSlot && (group == GRP_REG);
            injEos <= lastSlot && (group == GRP_INJ);
            if (lastSlot && !contEn) begin
              state <= ST_IDLE;
              slot  <= '0;
            end else begin
              slot      <= nextSlot;
              convStart <= 1'b1;
              convChan  <= nextChan;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int DATA_W    = DATA_W_DEF,
  parameter int INJ_SLOTS = INJ_SLOTS_DEF
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobeT                    strb,
  input  logic [DATA_W-1:0]           convData,
  input  logic                        dmaAck,
  output logic [DATA_W-1:0]           regData,
  output logic                        dmaReq,
  output logic                        overrun,
  output logic [INJ_SLOTS*DATA_W-1:0] injData
);
  // Regular result register with request/acknowledge toward DMA.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regData <= '0;
      dmaReq  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      overrun <= strb.wrReg && dmaReq && !dmaAck;
      if (strb.wrReg) begin
        regData <= convData;
        dmaReq  <= 1'b1;
      end else if (dmaAck) begin
        dmaReq  <= 1'b0;
      end
    end
  end

  // One result register per injected rank.
  for (genvar g = 0; g < INJ_SLOTS; g++) begin : gInjRank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        injData[g*DATA_W +: DATA_W] <= '0;
      end else if (strb.wrInj && (int'(strb.injRank) == g)) begin
        injData[g*DATA_W +: DATA_W] <= convData;
      end
    end
  end
endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int REG_SLOTS = REG_SLOTS_DEF,
  parameter int INJ_SLOTS = INJ_SLOTS_DEF,
  parameter int CHAN_W    = CHAN_W_DEF,
  parameter int DATA_W    = DATA_W_DEF
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         scanEn,
  input  logic                         contEn,
  input  logic [$clog2(REG_SLOTS)-1:0] regLen,
  input  logic [REG_SLOTS*CHAN_W-1:0]  regChans,
  input  logic [$clog2(INJ_SLOTS)-1:0] injLen,
  input  logic [INJ_SLOTS*CHAN_W-1:0]  injChans,
  input  logic                         regStart,
  input  logic                         injStart,
  input  logic                         convDone,
  input  logic [DATA_W-1:0]            convData,
  input  logic                         dmaAck,
  output logic                         convStart,
  output logic [CHAN_W-1:0]            convChan,
  output logic                         busy,
  output logic                         regEos,
  output logic                         injEos,
  output logic [DATA_W-1:0]            regData,
  output logic                         dmaReq,
  output logic                         overrun,
  output logic [INJ_SLOTS*DATA_W-1:0]  injData
);
  dpStrobeT strb;

  adcSeqControl #(.REG_SLOTS(REG_SLOTS), .INJ_SLOTS(INJ_SLOTS), .CHAN_W(CHAN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .contEn(contEn),
    .regLen(regLen), .regChans(regChans), .injLen(injLen), .injChans(injChans),
    .regStart(regStart), .injStart(injStart), .convDone(convDone),
    .convStart(convStart), .convChan(convChan), .busy(busy),
    .regEos(regEos), .injEos(injEos), .strb(strb)
  );

  adcSeqDatapath #(.DATA_W(DATA_W), .INJ_SLOTS(INJ_SLOTS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .convData(convData), .dmaAck(dmaAck),
    .regData(regData), .dmaReq(dmaReq), .overrun(overrun), .injData(injData)
  );
endmodule

// File: rtl/adcSeqChecker.sv
module adcSeqChecker
  import adcSeqPkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input logic              clk,
  input logic              rstN,
  input logic              regStart,
  input logic              injStart,
  input logic              convDone,
  input logic              convStart,
  input logic              busy,
  input logic              regEos,
  input logic              injEos,
  input logic              dmaReq,
  input logic              dmaAck,
  input logic              overrun,
  input logic [DATA_W-1:0] regData,
  input dpStrobeT          strb
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regStart || injStart) && !busy |=> convStart && busy);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    convStart && !convDone |=> !convStart);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !regStart && !injStart |=> !convStart);

  assert_eos_after_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regEos || injEos) |-> $past(convDone));

  assert_eos_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(regEos && injEos));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !dmaAck |=> dmaReq);

  assert_req_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> $past(convDone));

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(dmaReq) && !$past(dmaAck));

  assert_inj_keeps_reg_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrInj |=> $stable(regData));
endmodule

bind adcSeqCtrl adcSeqChecker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .regStart(regStart), .injStart(injStart),
  .convDone(convDone), .convStart(convStart), .busy(busy),
  .regEos(regEos), .injEos(injEos), .dmaReq(dmaReq), .dmaAck(dmaAck),
  .overrun(overrun), .regData(regData), .strb(strb)
);

// File: tb/adcSeqCtrl_tb.sv
module adcSeqCtrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scanEn = 1'b0, contEn = 1'b0;
  logic [3:0]  regLen = '0;
  logic [79:0] regChans = '0;
  logic [1:0]  injLen = '0;
  logic [19:0] injChans = '0;
  logic        regStart = 1'b0, injStart = 1'b0;
  logic        monDone = 1'b0, spurDone = 1'b0;
  logic [11:0] monData = '0, spurData = '0;
  logic        autoAck = 1'b1, manualAck = 1'b0, autoAckQ = 1'b0;
  logic        convDone, dmaAck;
  logic [11:0] convData;
  logic        convStart, busy, regEos, injEos, dmaReq, overrun;
  logic [4:0]  convChan;
  logic [11:0] regData;
  logic [47:0] injData;

  assign convDone = monDone | spurDone;
  assign convData = spurDone ? spurData : monData;
  assign dmaAck   = autoAckQ | manualAck;

  adcSeqCtrl dut_i (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .contEn(contEn),
    .regLen(regLen), .regChans(regChans), .injLen(injLen), .injChans(injChans),
    .regStart(regStart), .injStart(injStart), .convDone(convDone),
    .convData(convData), .dmaAck(dmaAck), .convStart(convStart),
    .convChan(convChan), .busy(busy), .regEos(regEos), .injEos(injEos),
    .regData(regData), .dmaReq(dmaReq), .overrun(overrun), .injData(injData)
  );

  always #10 clk = ~clk;

  typedef struct {
    int chan;
    bit inj;
    int rank;
    bit eos;
    bit ovr;
  } itemT;

  itemT        expQ[$];
  int          checks = 0, errors = 0, doneCnt = 0, cycles = 0, convSeq = 0;
  logic [11:0] lastReg = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finishSim();
    end
  end

  // Automatic DMA acknowledge: one-cycle pulse after a request is seen.
  always @(negedge clk) autoAckQ = autoAck && dmaReq && !autoAckQ;

  task automatic pushItem(input int chan, input bit inj, input int rank, input bit eos, input bit ovr);
    itemT it;
    it.chan = chan; it.inj = inj; it.rank = rank; it.eos = eos; it.ovr = ovr;
    expQ.push_back(it);
  endtask

  // Converter model and result monitor (scoreboard side).
  initial begin
    forever begin
      @(negedge clk);
      while (convStart) begin
        itemT        it;
        logic [11:0] d;
        if (expQ.size() == 0) begin
          check(1'b0, "R11 unexpected conversion", int'(convChan), -1);
          it.chan = int'(convChan); it.inj = 1'b0; it.rank = 0; it.eos = 1'b0; it.ovr = 1'b0;
        end else begin
          it = expQ.pop_front();
          check(int'(convChan) == it.chan, "R3 channel order", int'(convChan), it.chan);
        end
        d = 12'((it.chan * 37 + convSeq * 5 + 1) & 12'hFFF);
        convSeq++;
        repeat (2) @(negedge clk);
        monDone = 1'b1;
        monData = d;
        @(negedge clk);
        monDone = 1'b0;
        if (it.inj) begin
          check(injData[it.rank*12 +: 12] == d, "R10 rank data", int'(injData[it.rank*12 +: 12]), int'(d));
          check(regData == lastReg, "R10 regular untouched", int'(regData), int'(lastReg));
          check(injEos == it.eos, "R7 injected eos", int'(injEos), int'(it.eos));
        end else begin
          check(regData == d, "R8 regular data", int'(regData), int'(d));
          check(dmaReq == 1'b1, "R8 request raised", int'(dmaReq), 1);
          check(overrun == it.ovr, "R9 overrun", int'(overrun), int'(it.ovr));
          check(regEos == it.eos, "R7 regular eos", int'(regEos), int'(it.eos));
          lastReg = d;
        end
        doneCnt++;
      end
    end
  end

  task automatic waitIdle();
    do @(negedge clk); while (expQ.size() != 0 || busy || convStart);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && expQ.size() == 0, "R3 pass complete", int'(busy), 0);
  endtask

  task automatic pulse(input bit inj, input bit reg_);
    @(negedge clk);
    injStart = inj; regStart = reg_;
    @(negedge clk);
    injStart = 1'b0; regStart = 1'b0;
  endtask

  initial begin
    int base;
    for (int k = 0; k < 16; k++) regChans[k*5 +: 5] = 5'(k + 3);
    for (int k = 0; k < 4; k++) injChans[k*5 +: 5] = 5'(20 + k);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!convStart && !busy && !dmaReq && !overrun && !regEos && !injEos,
          "R1 reset controls", int'({convStart, busy, dmaReq, overrun}), 0);
    check(regData == 0 && injData == 0, "R1 reset data", int'(regData), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3/R4: regular scan of three slots
    scanEn = 1'b1; regLen = 4'd2;
    pushItem(3, 0, 0, 0, 0); pushItem(4, 0, 0, 0, 0); pushItem(5, 0, 0, 1, 0);
    @(negedge clk); regStart = 1'b1;
    @(negedge clk); regStart = 1'b0;
    check(convStart == 1'b1 && busy == 1'b1, "R2 start pulse", int'(convStart), 1);
    check(convChan == 5'd3, "R2 first channel", int'(convChan), 3);
    waitIdle();

    // R5: scan off converts only slot 0
    scanEn = 1'b0; regLen = 4'd3;
    pushItem(3, 0, 0, 1, 0);
    pulse(1'b0, 1'b1);
    waitIdle();

    // R10/R11: injected scan of four ranks with a stray regular strobe
    scanEn = 1'b1; injLen = 2'd3;
    pushItem(20, 1, 0, 0, 0); pushItem(21, 1, 1, 0, 0);
    pushItem(22, 1, 2, 0, 0); pushItem(23, 1, 3, 1, 0);
    pulse(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    pulse(1'b0, 1'b1);
    waitIdle();

    // R6/R7: continuous wrap, then stop at end of second pass
    contEn = 1'b1; regLen = 4'd1;
    pushItem(3, 0, 0, 0, 0); pushItem(4, 0, 0, 1, 0);
    pushItem(3, 0, 0, 0, 0); pushItem(4, 0, 0, 1, 0);
    base = doneCnt;
    pulse(1'b0, 1'b1);
    wait (doneCnt >= base + 3);
    contEn = 1'b0;
    waitIdle();
    check(doneCnt == base + 4, "R6 stopped after pass", doneCnt - base, 4);

    // R11: simultaneous strobes, injected wins
    injLen = 2'd0;
    pushItem(20, 1, 0, 1, 0);
    pulse(1'b1, 1'b1);
    waitIdle();

    // R9: overrun with acknowledge withheld
    autoAck = 1'b0; regLen = 4'd2;
    pushItem(3, 0, 0, 0, 0); pushItem(4, 0, 0, 0, 1); pushItem(5, 0, 0, 1, 1);
    pulse(1'b0, 1'b1);
    waitIdle();
    check(dmaReq == 1'b1, "R8 request held", int'(dmaReq), 1);
    manualAck = 1'b1;
    @(negedge clk);
    manualAck = 1'b0;
    @(negedge clk);
    check(dmaReq == 1'b0, "R8 request cleared", int'(dmaReq), 0);

    // R12: done while idle changes nothing
    spurDone = 1'b1; spurData = 12'hABC;
    @(negedge clk);
    spurDone = 1'b0;
    @(negedge clk);
    check(regData == lastReg && !dmaReq, "R12 idle done ignored", int'(regData), int'(lastReg));
    check(!convStart && !busy && !regEos && !injEos, "R12 idle quiet", int'({convStart, busy}), 0);

    finishSim();
  end
endmodule